// File: doc/BRIEF.md
# Five-channel timer register controller

This block is the register front end for a group of five countdown timer channels. A simple 32-bit bus reaches every register within a 4 KiB window. Each access is a single cycle: read data is valid during the access, and a write takes effect at the clock edge that ends it. The block stores each channel's control word and reload (initial count) value and gives them to the counting logic outside it. It also returns each channel's live count on reads.

The block owns the shared pending-flag register. A terminal-count pulse from a channel sets that channel's flag. Software clears flags by writing ones to that register. Each channel drives its own registered interrupt line, which is high when the channel's flag is pending and the interrupt-enable bit (bit 29) of its control word is set. A watchdog control word is readable but cannot be written. All other offsets read as zero.

Top module: `tmr_regctl`

## Requirements
- R1: Control words of channels 0..4 are read/write at byte offsets 0x00, 0x04, 0x20, 0x24, 0x40. Reload values are read/write at 0x08, 0x0C, 0x28, 0x2C, 0x48. Both are presented on `chanCtrl`/`chanInit` from the edge after the write.
- R2: Reads at 0x10, 0x14, 0x30, 0x34, 0x50 return `chanCount` of channels 0..4. Writes there change no stored register and raise no strobe.
- R3: A pulse on `chanExpire[i]` sets bit i of the pending register. That register reads at 0x18, with bits 31..5 reading zero.
- R4: Writing 0x18 clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R5: When an expiry and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: `irq[i]` is a register that equals pending bit i AND control bit 29 of channel i, both as updated by the same edge. A clear or an enable change therefore shows on the line one cycle after the write.
- R7: The watchdog word at 0x1C reads 0x00000400, and writes to it have no effect.
- R8: Reads of unmapped offsets, and of any address with bits 1..0 not zero, return 0. Writes there are ignored.
- R9: After reset, control words are 0x00000005, reload values are 0, the pending register is 0 and every `irq` line is low.
- R10: A write to channel i's control or reload offset raises `chanCtrlWr[i]` or `chanInitWr[i]` for that access cycle only. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during a read access |
| chanCount | input | 5x32 | Live count from each channel |
| chanExpire | input | 5 | Terminal-count pulse per channel |
| chanCtrl | output | 5x32 | Stored control word per channel |
| chanInit | output | 5x32 | Stored reload value per channel |
| chanCtrlWr | output | 5 | Control-word write strobe per channel |
| chanInitWr | output | 5 | Reload write strobe per channel |
| irq | output | 5 | Registered interrupt line per channel |

## Verification
The properties assume that bus inputs and expiry pulses are stable around the rising edge. They also assume an access lasts exactly one cycle and is never retried or stretched by the block. The stimulus drives every input on the falling edge and holds it for one full cycle. It mixes random accesses to mapped, unmapped and misaligned offsets with random expiry pulses, so clears, enable toggles and expiries often coincide on the same channel. This exercises the set-wins rule without ever breaking the timing assumption.

// File: rtl/tmr_regctl_pkg.sv
package tmr_regctl_pkg;
  parameter int NUM_CH = 5;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 12;
  parameter int IE_BIT = 29;
  parameter logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0005;
  parameter logic [DATA_W-1:0] WDOG_VALUE = 32'h0000_0400;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int WORD_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_INIT, RD_CNT, RD_PEND, RD_WDOG
  } rdKind_e;

  typedef struct packed {
    logic [NUM_CH-1:0] ctrlWr;
    logic [NUM_CH-1:0] initWr;
    logic              pendWr;
    rdKind_e           rdKind;
    logic [CH_W-1:0]   rdCh;
  } strobe_t;
endpackage

// File: rtl/tmr_regctl_ctl.sv
module tmr_regctl_ctl
  import tmr_regctl_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  rdKind_e         kind;
  logic [CH_W-1:0] ch;
  logic [WORD_W-1:0] word;

  assign word = busAddr[ADDR_W-1:2];

  always_comb begin
    kind = RD_NONE;
    ch   = '0;
    if (busAddr[1:0] == 2'b00) begin
      case (word)
        WORD_W'(0):  begin kind = RD_CTRL; ch = CH_W'(0); end
        WORD_W'(1):  begin kind = RD_CTRL; ch = CH_W'(1); end
        WORD_W'(2):  begin kind = RD_INIT; ch = CH_W'(0); end
        WORD_W'(3):  begin kind = RD_INIT; ch = CH_W'(1); end
        WORD_W'(4):  begin kind = RD_CNT;  ch = CH_W'(0); end
        WORD_W'(5):  begin kind = RD_CNT;  ch = CH_W'(1); end
        WORD_W'(6):  kind = RD_PEND;
        WORD_W'(7):  kind = RD_WDOG;
        WORD_W'(8):  begin kind = RD_CTRL; ch = CH_W'(2); end
        WORD_W'(9):  begin kind = RD_CTRL; ch = CH_W'(3); end
        WORD_W'(10): begin kind = RD_INIT; ch = CH_W'(2); end
        WORD_W'(11): begin kind = RD_INIT; ch = CH_W'(3); end
        WORD_W'(12): begin kind = RD_CNT;  ch = CH_W'(2); end
        WORD_W'(13): begin kind = RD_CNT;  ch = CH_W'(3); end
        WORD_W'(16): begin kind = RD_CTRL; ch = CH_W'(4); end
        WORD_W'(18): begin kind = RD_INIT; ch = CH_W'(4); end
        WORD_W'(20): begin kind = RD_CNT;  ch = CH_W'(4); end
        default: kind = RD_NONE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.rdCh   = ch;
    strb.rdKind = (busValid && !busWrite) ? kind : RD_NONE;
    if (busValid && busWrite) begin
      strb.pendWr = (kind == RD_PEND);
      for (int i = 0; i < NUM_CH; i++) begin
        strb.ctrlWr[i] = (kind == RD_CTRL) && (ch == CH_W'(i));
        strb.initWr[i] = (kind == RD_INIT) && (ch == CH_W'(i));
      end
    end
  end
endmodule

// File: rtl/tmr_regctl_dp.sv
module tmr_regctl_dp
  import tmr_regctl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanCount,
  input  logic [NUM_CH-1:0]              chanExpire,
  output logic [DATA_W-1:0]              busRdata,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanCtrl,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanInit,
  output logic [NUM_CH-1:0]              irq
);
  logic [NUM_CH-1:0] pendQ, pendNext, ieNext, clrMask;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrlNext;

  assign clrMask  = strb.pendWr ? busWdata[NUM_CH-1:0] : '0;
  assign pendNext = (pendQ & ~clrMask) | chanExpire;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ctrlNext[g] = strb.ctrlWr[g] ? busWdata : chanCtrl[g];
    assign ieNext[g]   = ctrlNext[g][IE_BIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanCtrl[g] <= CTRL_RESET;
        chanInit[g] <= '0;
      end else begin
        chanCtrl[g] <= ctrlNext[g];
        if (strb.initWr[g]) chanInit[g] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      irq   <= '0;
    end else begin
      pendQ <= pendNext;
      irq   <= pendNext & ieNext;
    end
  end

  always_comb begin
    busRdata = '0;
    if (32'(strb.rdCh) < NUM_CH) begin
      case (strb.rdKind)
        RD_CTRL: busRdata = chanCtrl[strb.rdCh];
        RD_INIT: busRdata = chanInit[strb.rdCh];
        RD_CNT:  busRdata = chanCount[strb.rdCh];
        RD_PEND: busRdata = DATA_W'(pendQ);
        RD_WDOG: busRdata = WDOG_VALUE;
        default: busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_regctl.sv
module tmr_regctl
  import tmr_regctl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chanCount,
  input  logic [NUM_CH-1:0]             chanExpire,
  output logic [NUM_CH-1:0][DATA_W-1:0] chanCtrl,
  output logic [NUM_CH-1:0][DATA_W-1:0] chanInit,
  output logic [NUM_CH-1:0]             chanCtrlWr,
  output logic [NUM_CH-1:0]             chanInitWr,
  output logic [NUM_CH-1:0]             irq
);
  strobe_t strb;

  tmr_regctl_ctl ctl_i (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strb(strb)
  );

  tmr_regctl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .chanCount(chanCount), .chanExpire(chanExpire), .busRdata(busRdata),
    .chanCtrl(chanCtrl), .chanInit(chanInit), .irq(irq)
  );

  assign chanCtrlWr = strb.ctrlWr;
  assign chanInitWr = strb.initWr;
endmodule

// File: rtl/tmr_regctl_chk.sv
module tmr_regctl_chk
  import tmr_regctl_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          busValid,
  input logic                          busWrite,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busWdata,
  input logic [NUM_CH-1:0]             chanExpire,
  input logic [NUM_CH-1:0][DATA_W-1:0] chanCtrl,
  input logic [NUM_CH-1:0][DATA_W-1:0] chanInit,
  input logic [NUM_CH-1:0]             chanCtrlWr,
  input logic [NUM_CH-1:0]             chanInitWr,
  input logic [NUM_CH-1:0]             irq
);
  logic [NUM_CH-1:0] ieVec;
  logic wrCnt, wrPend;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ie
    assign ieVec[g] = chanCtrl[g][IE_BIT];
  end

  assign wrCnt = busValid && busWrite &&
    (busAddr == 12'h010 || busAddr == 12'h014 || busAddr == 12'h030 ||
     busAddr == 12'h034 || busAddr == 12'h050);
  assign wrPend = busValid && busWrite && (busAddr == 12'h018);

  AST_EXPIRE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    |(chanExpire & ieVec & ~chanCtrlWr) |=>
      ((irq & $past(chanExpire & ieVec & ~chanCtrlWr)) == $past(chanExpire & ieVec & ~chanCtrlWr))); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~ieVec) == '0); // R6

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wrPend |=> ((irq & $past(busWdata[NUM_CH-1:0] & ~chanExpire)) == '0)); // R4

  AST_COUNT_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |=> ($stable(chanCtrl) && $stable(chanInit))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chanCtrlWr, chanInitWr})); // R10
endmodule

bind tmr_regctl tmr_regctl_chk chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .chanExpire(chanExpire),
  .chanCtrl(chanCtrl), .chanInit(chanInit), .chanCtrlWr(chanCtrlWr),
  .chanInitWr(chanInitWr), .irq(irq)
);

// File: tb/tmr_regctl_tb_top.sv
module tmr_regctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0][31:0] chanCount = '0;
  logic [4:0] chanExpire = '0;
  logic [4:0][31:0] chanCtrl, chanInit;
  logic [4:0] chanCtrlWr, chanInitWr, irq;

  int checks = 0, errors = 0;
  logic [31:0] ctrlM [5];
  logic [31:0] initM [5];
  logic [4:0] pendM, irqM;

  always #10 clk = ~clk;

  tmr_regctl dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .chanCount(chanCount), .chanExpire(chanExpire), .chanCtrl(chanCtrl),
    .chanInit(chanInit), .chanCtrlWr(chanCtrlWr), .chanInitWr(chanInitWr),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Offset decode from the requirements: kind 1=ctrl 2=init 3=count 4=pend 5=wdog 0=none
  function automatic int kindOf(input logic [11:0] a, output int ch);
    ch = 0;
    case (a)
      12'h000: begin ch = 0; return 1; end
      12'h004: begin ch = 1; return 1; end
      12'h020: begin ch = 2; return 1; end
      12'h024: begin ch = 3; return 1; end
      12'h040: begin ch = 4; return 1; end
      12'h008: begin ch = 0; return 2; end
      12'h00C: begin ch = 1; return 2; end
      12'h028: begin ch = 2; return 2; end
      12'h02C: begin ch = 3; return 2; end
      12'h048: begin ch = 4; return 2; end
      12'h010: begin ch = 0; return 3; end
      12'h014: begin ch = 1; return 3; end
      12'h030: begin ch = 2; return 3; end
      12'h034: begin ch = 3; return 3; end
      12'h050: begin ch = 4; return 3; end
      12'h018: return 4;
      12'h01C: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    int ch;
    int k = kindOf(a, ch);
    case (k)
      1: return ctrlM[ch];
      2: return initM[ch];
      3: return chanCount[ch];
      4: return {27'd0, pendM};
      5: return 32'h0000_0400;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input bit v, input bit w, input logic [11:0] a,
                      input logic [31:0] d, input logic [4:0] ex);
    int ch;
    int k;
    logic [4:0] expCw, expIw, ie;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d; chanExpire = ex;
    for (int i = 0; i < 5; i++) chanCount[i] = $urandom;
    k = kindOf(a, ch);
    expCw = '0; expIw = '0;
    if (v && w && k == 1) expCw[ch] = 1'b1;
    if (v && w && k == 2) expIw[ch] = 1'b1;
    #2;
    if (v && !w) check(busRdata == expRead(a), "R1/R2/R3/R7/R8 read", busRdata, expRead(a));
    check(chanCtrlWr == expCw && chanInitWr == expIw, "R10 strobes",
          {22'd0, chanCtrlWr, chanInitWr}, {22'd0, expCw, expIw});
    @(posedge clk);
    if (v && w) begin
      if (k == 1) ctrlM[ch] = d;
      if (k == 2) initM[ch] = d;
      if (k == 4) pendM = pendM & ~d[4:0];
    end
    pendM = pendM | ex;
    for (int i = 0; i < 5; i++) ie[i] = ctrlM[i][29];
    irqM = pendM & ie;
    #2;
    check(irq == irqM, "R6 irq", {27'd0, irq}, {27'd0, irqM});
    for (int i = 0; i < 5; i++) begin
      check(chanCtrl[i] == ctrlM[i], "R1 chanCtrl", chanCtrl[i], ctrlM[i]);
      check(chanInit[i] == initM[i], "R1 chanInit", chanInit[i], initM[i]);
    end
  endtask

  task automatic rd(input logic [11:0] a);
    step(1'b1, 1'b0, a, 32'h0, 5'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] addrList [18];
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) begin ctrlM[i] = 32'h5; initM[i] = 32'h0; end
    pendM = '0; irqM = '0;
    addrList = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
                 12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034,
                 12'h040, 12'h048, 12'h050, 12'h03C};
    repeat (3) @(negedge clk);
    // R9: reset values
    check(irq == 5'h0, "R9 irq", {27'd0, irq}, 32'h0);
    for (int i = 0; i < 5; i++) begin
      check(chanCtrl[i] == 32'h5, "R9 ctrl", chanCtrl[i], 32'h5);
      check(chanInit[i] == 32'h0, "R9 init", chanInit[i], 32'h0);
    end
    rstN = 1'b1;
    rd(12'h018); // R9 pending reads zero
    // R7: watchdog write ignored
    step(1'b1, 1'b1, 12'h01C, 32'hFFFF_FFFF, 5'h0);
    rd(12'h01C);
    // R8: misaligned and unmapped writes ignored
    step(1'b1, 1'b1, 12'h001, 32'hDEAD_BEEF, 5'h0);
    step(1'b1, 1'b1, 12'h044, 32'hDEAD_BEEF, 5'h0);
    rd(12'h000); rd(12'h001); rd(12'h044); rd(12'hFFC);
    // R2: count write ignored
    step(1'b1, 1'b1, 12'h050, 32'h1234_5678, 5'h0);
    rd(12'h050);
    // R6/R3: enable channel 4, expire it, then clear it (R4)
    step(1'b1, 1'b1, 12'h040, 32'h2000_0000, 5'h0);
    step(1'b0, 1'b0, 12'h000, 32'h0, 5'h10);
    rd(12'h018);
    // R5: clear and expire collide on channel 4
    step(1'b1, 1'b1, 12'h018, 32'h0000_0010, 5'h10);
    rd(12'h018);
    step(1'b1, 1'b1, 12'h018, 32'h0000_0010, 5'h0);
    rd(12'h018);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [4:0] ex;
      a = ($urandom_range(0, 9) == 0) ? 12'($urandom) : addrList[$urandom_range(0, 17)];
      d = $urandom;
      if ($urandom_range(0, 1) == 1) d[29] = 1'b1;
      ex = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, a, d, ex);
    end
    step(1'b0, 1'b0, 12'h0, 32'h0, 5'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule